// File: doc/BRIEF.md
# Triplicated Scrubbed Word Memory

This block is a small word-addressed store built to tolerate upsets in its own state. It holds three full copies of the data array, each with two ports. The first port of every copy serves the user: a write lands in all three copies at once, and a read takes the word from each copy and returns the bit-by-bit majority of the three. The second port of every copy belongs to a refresh engine. Each cycle the engine visits one address, reads that word from all three copies, takes the majority, and writes the result back into every copy. A bit flipped in one copy is therefore outvoted on every read, and it is overwritten within one full pass of the engine. This stops a second upset in another copy from combining with it.

The refresh engine keeps one address counter per copy. Each counter loads the majority of the three counters plus one. A corrupted counter is corrected on its next step. The engine does not depend on the data held in the array and never stops. Its voted address is visible at `scrub_addr`.

The user side is a request/response stream with no back-pressure. A request is taken in any cycle in which `req_valid` is high, and there is no ready signal. A read response appears with `rsp_valid` exactly one cycle later and cannot be stalled. A write produces no response. A separate fault-injection input is provided for test. It XORs a mask into one chosen copy at one address.

Top module: `tmr_scrub_ram`

## Requirements
- R1: While reset is high and after it is released, every word of every copy reads as zero, `scrub_addr` is 0 and `rsp_valid` is 0.
- R2: `scrub_addr` advances by exactly one on every clock after reset and returns from DEPTH-1 to 0.
- R3: A read request (`req_valid`=1, `req_we`=0) raises `rsp_valid` in the next cycle, with the voted word as stored before that edge. A write request or no request leaves `rsp_valid` at 0 in the next cycle.
- R4: A write request (`req_valid`=1, `req_we`=1) stores `req_wdata` at `req_addr` in all three copies at the same edge.
- R5: When a user write targets the address being refreshed in that cycle, the user data is stored and the refresh write-back for that address is dropped.
- R6: A fault in one copy only never shows on a read. `inj_copy` selects copy 0, 1 or 2, and the value 3 selects none. `inj_mask` is XORed into that copy's word at `inj_addr`, on top of any write in the same cycle.
- R7: After a refresh has passed an address in which only one copy differs, all three copies hold the majority word. Any single-copy fault is therefore removed within DEPTH cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | W | Voted read word |
| scrub_addr | output | AW | Voted address of the refresh engine |
| inj_en | input | 1 | Apply a fault-injection mask this cycle |
| inj_copy | input | 2 | Copy to corrupt (0..2; 3 = none) |
| inj_addr | input | AW | Address to corrupt |
| inj_mask | input | W | Bits to invert |

## Verification
On every cycle, the assertions check the following. The refresh address steps by one and wraps. The response follows a read by one cycle. A user write reaches all three copies, including when it collides with the refresh. The copies agree at each address the refresh has just handled. The bench scenarios cover what can only be seen across many cycles at the ports. Reads stay correct while one copy is corrupted. Two faults on the same bits in different copies, placed a full refresh pass apart, still read back correctly, which shows that the first fault was repaired.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NCOPY = 3;
  localparam int unsigned SEL_W = 2;

  function automatic logic maj_bit(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] voted
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign voted[b] = tmr_pkg::maj_bit(in_a[b], in_b[b], in_c[b]);
  end
endmodule

// File: rtl/tmr_scrub_ctr.sv
module tmr_scrub_ctr #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] voted_cnt,
  output logic [AW-1:0] cnt
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (voted_cnt == LAST) cnt <= '0;
    else                        cnt <= voted_cnt + AW'(1);
  end
endmodule

// File: rtl/tmr_ram_copy.sv
module tmr_ram_copy #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  parameter int unsigned AW    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  // user port
  input  logic [AW-1:0]           ua_addr,
  input  logic                    ua_we,
  input  logic [W-1:0]            ua_wdata,
  output logic [W-1:0]            ua_rdata,
  // refresh port
  input  logic [AW-1:0]           sb_addr,
  input  logic                    sb_we,
  input  logic [W-1:0]            sb_wdata,
  output logic [W-1:0]            sb_rdata,
  // fault injection
  input  logic                    flip_en,
  input  logic [AW-1:0]           flip_addr,
  input  logic [W-1:0]            flip_mask,
  output logic [DEPTH-1:0][W-1:0] contents
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [W-1:0] word_q;
    logic [W-1:0] word_d;

    always_comb begin
      word_d = word_q;
      if (sb_we && sb_addr == AW'(i)) word_d = sb_wdata;
      // user port wins over the refresh port
      if (ua_we && ua_addr == AW'(i)) word_d = ua_wdata;
      if (flip_en && flip_addr == AW'(i)) word_d = word_d ^ flip_mask;
    end

    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else     word_q <= word_d;
    end

    assign contents[i] = word_q;
  end

  assign sb_rdata = contents[sb_addr];

  always_ff @(posedge clk) begin
    if (rst) ua_rdata <= '0;
    else     ua_rdata <= contents[ua_addr];
  end
endmodule

// File: rtl/tmr_scrub_ram.sv
module tmr_scrub_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  parameter int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_wdata,
  output logic          rsp_valid,
  output logic [W-1:0]  rsp_rdata,
  output logic [AW-1:0] scrub_addr,
  input  logic          inj_en,
  input  logic [1:0]    inj_copy,
  input  logic [AW-1:0] inj_addr,
  input  logic [W-1:0]  inj_mask
);
  localparam int unsigned N = tmr_pkg::NCOPY;

  logic [AW-1:0]           cnt     [N];
  logic [AW-1:0]           cnt_v   [N];
  logic [W-1:0]            sb_rd   [N];
  logic [W-1:0]            sb_wb   [N];
  logic [W-1:0]            ua_rd   [N];
  logic [N-1:0]            sb_we;
  logic [N-1:0]            flip_en;
  logic [DEPTH-1:0][W-1:0] cont    [N];
  logic [DEPTH-1:0][W-1:0] view0, view1, view2;
  logic                    user_wr;

  assign user_wr = req_valid & req_we;

  for (genvar k = 0; k < N; k++) begin : g_copy
    tmr_vote #(.W(AW)) u_cnt_vote (
      .in_a(cnt[0]), .in_b(cnt[1]), .in_c(cnt[2]), .voted(cnt_v[k])
    );

    tmr_scrub_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
      .clk(clk), .rst(rst), .voted_cnt(cnt_v[k]), .cnt(cnt[k])
    );

    tmr_vote #(.W(W)) u_wb_vote (
      .in_a(sb_rd[0]), .in_b(sb_rd[1]), .in_c(sb_rd[2]), .voted(sb_wb[k])
    );

    // drop the refresh write when the user writes the same word
    assign sb_we[k]   = !(user_wr && req_addr == cnt[k]);
    assign flip_en[k] = inj_en && (inj_copy == tmr_pkg::SEL_W'(k));

    tmr_ram_copy #(.DEPTH(DEPTH), .W(W), .AW(AW)) u_ram (
      .clk(clk), .rst(rst),
      .ua_addr(req_addr), .ua_we(user_wr), .ua_wdata(req_wdata), .ua_rdata(ua_rd[k]),
      .sb_addr(cnt[k]), .sb_we(sb_we[k]), .sb_wdata(sb_wb[k]), .sb_rdata(sb_rd[k]),
      .flip_en(flip_en[k]), .flip_addr(inj_addr), .flip_mask(inj_mask),
      .contents(cont[k])
    );
  end

  assign view0 = cont[0];
  assign view1 = cont[1];
  assign view2 = cont[2];

  tmr_vote #(.W(W)) u_rd_vote (
    .in_a(ua_rd[0]), .in_b(ua_rd[1]), .in_c(ua_rd[2]), .voted(rsp_rdata)
  );

  tmr_vote #(.W(AW)) u_addr_vote (
    .in_a(cnt[0]), .in_b(cnt[1]), .in_c(cnt[2]), .voted(scrub_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= req_valid & ~req_we;
  end
endmodule

// File: rtl/tmr_scrub_ram_chk.sv
module tmr_scrub_ram_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  parameter int unsigned AW    = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_we,
  input logic [AW-1:0]           req_addr,
  input logic [W-1:0]            req_wdata,
  input logic                    rsp_valid,
  input logic [AW-1:0]           scrub_addr,
  input logic                    inj_en,
  input logic [DEPTH-1:0][W-1:0] v0,
  input logic [DEPTH-1:0][W-1:0] v1,
  input logic [DEPTH-1:0][W-1:0] v2
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  a_r2_scrub_step: assert property (@(posedge clk) disable iff (rst)
    (scrub_addr != LAST) |=> scrub_addr == $past(scrub_addr) + AW'(1));

  a_r2_scrub_wrap: assert property (@(posedge clk) disable iff (rst)
    (scrub_addr == LAST) |=> scrub_addr == '0);

  a_r3_rsp_follows_read: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we) |=> rsp_valid);

  a_r3_no_rsp_otherwise: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_we) |=> !rsp_valid);

  a_r4_write_all_copies: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && !inj_en) |=>
      (v0[$past(req_addr)] == $past(req_wdata)) &&
      (v1[$past(req_addr)] == $past(req_wdata)) &&
      (v2[$past(req_addr)] == $past(req_wdata)));

  a_r5_user_beats_scrub: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && !inj_en && req_addr == scrub_addr) |=>
      (v0[$past(scrub_addr)] == $past(req_wdata)) &&
      (v1[$past(scrub_addr)] == $past(req_wdata)));

  a_r7_copies_agree: assert property (@(posedge clk) disable iff (rst)
    (!inj_en && !(req_valid && req_we && req_addr == scrub_addr)) |=>
      (v0[$past(scrub_addr)] == v1[$past(scrub_addr)]) &&
      (v1[$past(scrub_addr)] == v2[$past(scrub_addr)]));
endmodule

bind tmr_scrub_ram tmr_scrub_ram_chk #(.DEPTH(DEPTH), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .scrub_addr(scrub_addr), .inj_en(inj_en),
  .v0(view0), .v1(view1), .v2(view2)
);

// File: tb/sim_tmr_scrub_ram.sv
module sim_tmr_scrub_ram;
  localparam int DEPTH = 16;
  localparam int W     = 8;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_we;
  logic [AW-1:0] req_addr, inj_addr;
  logic [W-1:0]  req_wdata, inj_mask;
  logic          rsp_valid;
  logic [W-1:0]  rsp_rdata;
  logic [AW-1:0] scrub_addr;
  logic          inj_en;
  logic [1:0]    inj_copy;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int cyc   = 0;
  int last_inj = -1000;
  logic [W-1:0] model [DEPTH];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  tmr_scrub_ram #(.DEPTH(DEPTH), .W(W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .scrub_addr(scrub_addr), .inj_en(inj_en),
    .inj_copy(inj_copy), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return (int'(a) == DEPTH - 1) ? '0 : a + AW'(1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic step(input bit rv, input bit we, input logic [AW-1:0] a,
                      input logic [W-1:0] d, input bit ie, input logic [1:0] ic,
                      input logic [AW-1:0] ia, input logic [W-1:0] im, input string req);
    req_valid = rv; req_we = we; req_addr = a; req_wdata = d;
    inj_en = ie; inj_copy = ic; inj_addr = ia; inj_mask = im;
    if (ie) last_inj = cyc;
    @(negedge clk);
    if (rv && we) begin
      model[a] = d;
      check(rsp_valid == 1'b0, {req, "/R3 no rsp on write"}, rsp_valid, 0);
    end else if (rv) begin
      check(rsp_valid == 1'b1, {req, "/R3 rsp_valid"}, rsp_valid, 1);
      check(rsp_rdata == model[a], req, rsp_rdata, model[a]);
    end
    req_valid = 0; req_we = 0; inj_en = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d, input string req);
    step(1, 1, a, d, 0, 0, 0, 0, req);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string req);
    step(1, 0, a, 0, 0, 0, 0, 0, req);
  endtask
  task automatic inject(input logic [1:0] c, input logic [AW-1:0] a, input logic [W-1:0] m);
    step(0, 0, 0, 0, 1, c, a, m, "inject");
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    rst = 1; req_valid = 0; req_we = 0; req_addr = 0; req_wdata = 0;
    inj_en = 0; inj_copy = 0; inj_addr = 0; inj_mask = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    check(scrub_addr == 0, "R1 scrub_addr after reset", scrub_addr, 0);
    check(rsp_valid == 0, "R1 rsp_valid after reset", rsp_valid, 0);
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), "R1 word zero");

    // R2: refresh address walk and wrap
    for (int i = 0; i < 2 * DEPTH + 3; i++) begin
      logic [AW-1:0] prev;
      prev = scrub_addr;
      idle(1);
      check(scrub_addr == next_addr(prev), "R2 scrub step", scrub_addr, next_addr(prev));
    end

    // R4 / R3: writes then back-to-back reads
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), W'(8'h3c ^ (a * 17)), "R4 write");
    for (int a = DEPTH - 1; a >= 0; a--) rd(AW'(a), "R4 readback");

    // R5: user write collides with the refresh address
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] s;
      s = scrub_addr;
      wr(s, W'(8'ha5 + i * 7), "R5 collide");
      rd(s, "R5 user data kept");
    end

    // R6: single-copy faults hidden from reads, every copy
    for (int c = 0; c < 3; c++) begin
      inject(2'(c), AW'(3 + c), 8'hff);
      rd(AW'(3 + c), "R6 masked fault");
      idle(DEPTH + 1);
    end
    // R6: inj_copy = 3 corrupts nothing, even when paired with a fault in copy 0
    inject(2'd3, AW'(9), 8'hff);
    inject(2'd0, AW'(9), 8'hff);
    rd(AW'(9), "R6 copy3 selects none");
    idle(DEPTH + 1);

    // R7: a second fault on the same bits in another copy after one pass
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      logic [1:0] c1, c2;
      a  = AW'($urandom_range(0, DEPTH - 1));
      c1 = 2'(i % 3);
      c2 = 2'((i + 1) % 3);
      inject(c1, a, 8'h5a);
      idle(DEPTH);
      inject(c2, a, 8'h5a);
      rd(a, "R7 repaired before second fault");
      idle(DEPTH + 1);
    end

    // random traffic with spaced single-copy faults
    last_inj = -1000;
    for (int n = 0; n < 3000; n++) begin
      int k;
      bit ie;
      k  = $urandom_range(0, 9);
      ie = ((cyc - last_inj) > DEPTH + 2) && ($urandom_range(0, 5) == 0);
      step(k < 8, k < 4, AW'($urandom_range(0, DEPTH - 1)), W'($urandom),
           ie, 2'($urandom_range(0, 2)), AW'($urandom_range(0, DEPTH - 1)),
           W'($urandom_range(1, 255)), "R6/R7 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule